// File: doc/BRIEF.md
# Flash Read Buffer Allocator

This block keeps a small, fully associative set of read buffers in front of a flash read path. Each entry remembers a flash word address, the word that was read, an error flag and a state: invalid, valid, or work-in-progress (a read has been issued and its data has not yet arrived). Every incoming read is compared against all entries at once. A match returns the buffered word without touching flash. A miss picks a victim entry, marks it work-in-progress with the new address, and tells the read path to go to flash.

When the downstream stage (descramble or plain forward) finishes, the fill strobe writes the returned word and its error flag into the work-in-progress entry, which then becomes valid. Program and erase requests flush any valid entry whose address they hit, so stale data is never returned.

A configuration enable turns buffering on or off. It is sampled only while the surrounding read pipeline reports idle. While buffering is off, every entry is held invalid and every read goes to flash.

Top module: `flash_rdbuf_alloc`

## Requirements
- R1: A read request (`req_op_i` = 00) whose address equals that of a valid or work-in-progress entry raises `hit_o` in the same cycle and does not raise `flash_rd_o`. `hit_wip_o` tells whether the matched entry is still in flight. For a valid entry, `hit_data_o` and `hit_err_o` carry that entry's stored word and flag.
- R2: A read that misses raises `flash_rd_o` in the same cycle. If allocation is permitted, it also raises exactly one bit of `alloc_o`, and from the next cycle that entry is work-in-progress with the request address.
- R3: The victim is the lowest-indexed invalid entry whenever any entry is invalid.
- R4: When no entry is invalid, the victim is the first valid entry found by searching upward, with wrap-around, from a round-robin pointer. The pointer starts at 0 and moves to one past the entry taken after each replacement from the valid set.
- R5: A work-in-progress entry is never chosen as victim. At most one entry is work-in-progress at a time. A miss that arrives while one is in flight reads flash without allocating anything.
- R6: `fill_i` writes `fill_data_i` and `fill_err_i` into the work-in-progress entry and makes it valid on the next cycle. A fill that arrives while no entry is in flight changes nothing.
- R7: A program (01), page-erase (10) or bank-erase (11) request whose address matches a valid entry invalidates that entry. A later read of that address then misses.
- R8: `buf_en_o` takes the value of `cfg_buf_en_i` only at a clock edge where `pipe_idle_i` is high. Otherwise it holds its value.
- R9: While `buf_en_o` is low, there is no hit and no allocation, every read raises `flash_rd_o`, and all entries are cleared to invalid at the next edge.
- R10: After reset, all entries are invalid, `buf_en_o` is low and the round-robin pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_buf_en_i | input | 1 | Requested buffer enable |
| pipe_idle_i | input | 1 | Read pipeline idle; enable may be sampled |
| req_i | input | 1 | Request strobe |
| req_op_i | input | 2 | 00 read, 01 program, 10 page erase, 11 bank erase |
| req_addr_i | input | ADDR_W | Flash word address |
| fill_i | input | 1 | Downstream stage completed |
| fill_data_i | input | DATA_W | Completed word |
| fill_err_i | input | 1 | Completed word error flag |
| hit_o | output | 1 | Read matched an entry |
| hit_wip_o | output | 1 | Matched entry still in flight |
| hit_data_o | output | DATA_W | Matched entry word |
| hit_err_o | output | 1 | Matched entry error flag |
| alloc_o | output | NUM_BUF | One-hot victim chosen this cycle |
| flash_rd_o | output | 1 | Read must go to flash |
| buf_en_o | output | 1 | Latched buffer enable |

## Verification
Hit, hit data, victim choice and the flash-read decision are combinational in the request. The bench therefore samples them in the same cycle as the request, one nanosecond before the rising edge. Allocation, fill, flush, pointer movement and the enable latch take effect at the next edge. The bench's reference state advances at that edge, so their effect shows up in the outputs of the following request. Directed steps place each case (lowest-invalid pick, round-robin wrap, miss while in flight, flush then re-read, disabled reads) in a known cycle. Random traffic over a small address set then follows.

// File: rtl/flash_rdbuf_alloc.sv
module flash_rdbuf_alloc #(
  parameter int NUM_BUF = 4,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_buf_en_i,
  input  logic              pipe_idle_i,
  input  logic              req_i,
  input  logic [1:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              fill_i,
  input  logic [DATA_W-1:0] fill_data_i,
  input  logic              fill_err_i,
  output logic              hit_o,
  output logic              hit_wip_o,
  output logic [DATA_W-1:0] hit_data_o,
  output logic              hit_err_o,
  output logic [NUM_BUF-1:0] alloc_o,
  output logic              flash_rd_o,
  output logic              buf_en_o
);
  localparam int IDX_W = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1;
  localparam logic [1:0] ST_INV = 2'b00;
  localparam logic [1:0] ST_VAL = 2'b01;
  localparam logic [1:0] ST_WIP = 2'b10;

  logic [1:0]        st_q   [NUM_BUF];
  logic [ADDR_W-1:0] addr_q [NUM_BUF];
  logic [DATA_W-1:0] data_q [NUM_BUF];
  logic [NUM_BUF-1:0] err_q;
  logic [IDX_W-1:0]  rr_q;
  logic              buf_en_q;

  logic [NUM_BUF-1:0] is_val, is_wip, is_inv, match;
  logic [NUM_BUF-1:0] inv_oh, val_oh;
  logic [IDX_W-1:0]   val_idx;
  logic               rd_req, wr_req, do_alloc;

  assign rd_req = req_i && (req_op_i == 2'b00);
  assign wr_req = req_i && (req_op_i != 2'b00);

  for (genvar i = 0; i < NUM_BUF; i++) begin : g_tag
    assign is_val[i] = st_q[i] == ST_VAL;
    assign is_wip[i] = st_q[i] == ST_WIP;
    assign is_inv[i] = !is_val[i] && !is_wip[i];
    assign match[i]  = buf_en_q && !is_inv[i] && (addr_q[i] == req_addr_i);
  end

  always_comb begin
    hit_wip_o  = 1'b0;
    hit_data_o = '0;
    hit_err_o  = 1'b0;
    for (int i = NUM_BUF - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_wip_o  = is_wip[i];
        hit_data_o = data_q[i];
        hit_err_o  = err_q[i];
      end
    end
  end

  always_comb begin
    logic found_inv, found_val;
    int j;
    inv_oh    = '0;
    val_oh    = '0;
    val_idx   = '0;
    found_inv = 1'b0;
    found_val = 1'b0;
    for (int i = 0; i < NUM_BUF; i++) begin
      if (is_inv[i] && !found_inv) begin
        inv_oh[i] = 1'b1;
        found_inv = 1'b1;
      end
    end
    for (int k = 0; k < NUM_BUF; k++) begin
      j = (int'(rr_q) + k) % NUM_BUF;
      if (is_val[j] && !found_val) begin
        val_oh[j] = 1'b1;
        val_idx   = IDX_W'(j);
        found_val = 1'b1;
      end
    end
  end

  assign hit_o      = rd_req && |match;
  assign flash_rd_o = rd_req && !(|match);
  assign do_alloc   = flash_rd_o && buf_en_q && !(|is_wip);
  assign alloc_o    = !do_alloc ? '0 : (|is_inv) ? inv_oh : val_oh;
  assign buf_en_o   = buf_en_q;

  for (genvar i = 0; i < NUM_BUF; i++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q[i]   <= ST_INV;
        addr_q[i] <= '0;
        data_q[i] <= '0;
        err_q[i]  <= 1'b0;
      end else if (!buf_en_q) begin
        st_q[i] <= ST_INV;
      end else if (alloc_o[i]) begin
        st_q[i]   <= ST_WIP;
        addr_q[i] <= req_addr_i;
      end else if (is_wip[i] && fill_i) begin
        st_q[i]   <= ST_VAL;
        data_q[i] <= fill_data_i;
        err_q[i]  <= fill_err_i;
      end else if (wr_req && is_val[i] && match[i]) begin
        st_q[i] <= ST_INV;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rr_q     <= '0;
      buf_en_q <= 1'b0;
    end else begin
      if (do_alloc && !(|is_inv)) rr_q <= IDX_W'((int'(val_idx) + 1) % NUM_BUF);
      if (pipe_idle_i) buf_en_q <= cfg_buf_en_i;
    end
  end
endmodule

// File: rtl/flash_rdbuf_alloc_chk.sv
module flash_rdbuf_alloc_chk #(
  parameter int NUM_BUF = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               pipe_idle_i,
  input logic               fill_i,
  input logic               hit_o,
  input logic               flash_rd_o,
  input logic               buf_en_o,
  input logic [NUM_BUF-1:0] alloc_o,
  input logic [NUM_BUF-1:0] wip_vec,
  input logic [NUM_BUF-1:0] inv_vec
);
  AST_HIT_NO_FLASH: assert property (@(posedge clk_i) disable iff (!rst_ni) hit_o |-> !flash_rd_o); // R1
  AST_ALLOC_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(alloc_o)); // R2
  AST_ALLOC_MARKS_WIP: assert property (@(posedge clk_i) disable iff (!rst_ni) (|alloc_o) |=> (|wip_vec)); // R2
  AST_ALLOC_PREFERS_INV: assert property (@(posedge clk_i) disable iff (!rst_ni) ((|alloc_o) && (|inv_vec)) |-> (|(alloc_o & inv_vec))); // R3
  AST_ALLOC_NOT_WIP: assert property (@(posedge clk_i) disable iff (!rst_ni) (alloc_o & wip_vec) == '0); // R5
  AST_SINGLE_WIP: assert property (@(posedge clk_i) disable iff (!rst_ni) $countones(wip_vec) <= 1); // R5
  AST_FILL_CLEARS_WIP: assert property (@(posedge clk_i) disable iff (!rst_ni) (fill_i && (|wip_vec)) |=> (wip_vec == '0)); // R6
  AST_EN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) !pipe_idle_i |=> $stable(buf_en_o)); // R8
  AST_OFF_NO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni) !buf_en_o |-> (!hit_o && alloc_o == '0)); // R9
endmodule

bind flash_rdbuf_alloc flash_rdbuf_alloc_chk #(.NUM_BUF(NUM_BUF)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pipe_idle_i(pipe_idle_i), .fill_i(fill_i),
  .hit_o(hit_o), .flash_rd_o(flash_rd_o), .buf_en_o(buf_en_o), .alloc_o(alloc_o),
  .wip_vec(is_wip), .inv_vec(is_inv)
);

// File: tb/test_flash_rdbuf_alloc.sv
module test_flash_rdbuf_alloc;
  localparam int NB = 4, AW = 16, DW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_en = 0, idle = 0, req = 0, fill = 0, ferr = 0;
  logic [1:0] op = 0;
  logic [AW-1:0] addr = 0;
  logic [DW-1:0] fdata = 0;
  logic hit, hit_wip, hit_err, flash_rd, buf_en;
  logic [DW-1:0] hit_data;
  logic [NB-1:0] alloc;

  int n_chk = 0, n_fail = 0;
  int m_st [NB];
  int m_ad [NB];
  logic [DW-1:0] m_dt [NB];
  bit m_er [NB];
  int m_rr = 0;
  bit m_en = 0;
  bit last_haz = 0;

  always #4 clk = ~clk;

  flash_rdbuf_alloc #(.NUM_BUF(NB), .ADDR_W(AW), .DATA_W(DW)) i_flash_rdbuf_alloc (
    .clk_i(clk), .rst_ni(rst_n), .cfg_buf_en_i(cfg_en), .pipe_idle_i(idle),
    .req_i(req), .req_op_i(op), .req_addr_i(addr), .fill_i(fill),
    .fill_data_i(fdata), .fill_err_i(ferr), .hit_o(hit), .hit_wip_o(hit_wip),
    .hit_data_o(hit_data), .hit_err_o(hit_err), .alloc_o(alloc),
    .flash_rd_o(flash_rd), .buf_en_o(buf_en)
  );

  task automatic chk(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int match_idx();
    for (int i = 0; i < NB; i++)
      if (m_en && m_st[i] != 0 && m_ad[i] == int'(addr)) return i;
    return -1;
  endfunction

  function automatic bit any_wip();
    for (int i = 0; i < NB; i++) if (m_st[i] == 2) return 1;
    return 0;
  endfunction

  function automatic bit any_inv();
    for (int i = 0; i < NB; i++) if (m_st[i] == 0) return 1;
    return 0;
  endfunction

  function automatic int victim();
    for (int i = 0; i < NB; i++) if (m_st[i] == 0) return i;
    for (int k = 0; k < NB; k++) if (m_st[(m_rr + k) % NB] == 1) return (m_rr + k) % NB;
    return -1;
  endfunction

  task automatic step(bit r, logic [1:0] o, int a, bit f, logic [DW-1:0] d, bit e, bit c, bit idl);
    int mi, v;
    bit rd, miss, al;
    logic [NB-1:0] exp_al;
    string atag;
    @(negedge clk);
    req = r; op = o; addr = AW'(a); fill = f; fdata = d; ferr = e; cfg_en = c; idle = idl;
    #3;
    mi = match_idx();
    rd = r && (o == 2'b00);
    miss = rd && (mi < 0);
    al = miss && m_en && !any_wip();
    v = al ? victim() : -1;
    exp_al = '0;
    if (v >= 0) exp_al[v] = 1'b1;
    atag = !m_en ? "R9" : any_wip() ? "R5" : any_inv() ? "R3" : "R4";
    chk(last_haz ? "R7" : (m_en ? "R1" : "R9"), "hit", DW'(hit), DW'(rd && mi >= 0));
    chk("R2", "flash_rd", DW'(flash_rd), DW'(miss));
    chk(atag, "alloc", DW'(alloc), DW'(exp_al));
    chk("R8", "buf_en", DW'(buf_en), DW'(m_en));
    if (rd && mi >= 0) begin
      chk("R1", "hit_wip", DW'(hit_wip), DW'(m_st[mi] == 2));
      if (m_st[mi] == 1) begin
        chk("R6", "hit_data", hit_data, m_dt[mi]);
        chk("R6", "hit_err", DW'(hit_err), DW'(m_er[mi]));
      end
    end
    last_haz = r && (o != 2'b00);
    for (int i = 0; i < NB; i++) begin
      if (!m_en) m_st[i] = 0;
      else if (i == v) begin m_st[i] = 2; m_ad[i] = a; end
      else if (m_st[i] == 2 && f) begin m_st[i] = 1; m_dt[i] = d; m_er[i] = e; end
      else if (last_haz && m_st[i] == 1 && m_ad[i] == a) m_st[i] = 0;
    end
    if (v >= 0 && !any_inv_before(v)) m_rr = (v + 1) % NB;
    if (idl) m_en = c;
    @(posedge clk);
  endtask

  bit inv_snapshot;
  function automatic bit any_inv_before(int v);
    return inv_snapshot;
  endfunction

  task automatic go(bit r, logic [1:0] o, int a, bit f, logic [DW-1:0] d, bit e, bit c, bit idl);
    inv_snapshot = any_inv();
    step(r, o, a, f, d, e, c, idl);
  endtask

  initial begin
    #1500000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < NB; i++) begin m_st[i] = 0; m_ad[i] = 0; m_dt[i] = '0; m_er[i] = 0; end
    repeat (3) @(posedge clk);
    #1;
    chk("R10", "buf_en after reset", DW'(buf_en), 0);
    rst_n = 1'b1;
    go(1, 0, 3, 0, 0, 0, 0, 0);
    chk("R9", "disabled read to flash", DW'(flash_rd), 1);
    go(0, 0, 0, 0, 0, 0, 1, 1);
    for (int i = 0; i < NB; i++) begin
      go(1, 0, i, 0, 0, 0, 1, 0);
      go(0, 0, 0, 1, DW'(32'hA000 + i), i[0], 1, 0);
    end
    go(1, 0, 2, 0, 0, 0, 1, 0);
    go(1, 0, 9, 0, 0, 0, 1, 0);
    go(1, 0, 10, 0, 0, 0, 1, 0);
    go(1, 0, 9, 1, 32'hBEEF, 1, 1, 0);
    go(1, 0, 9, 0, 0, 0, 1, 0);
    go(0, 0, 0, 1, 32'h1234, 0, 1, 0);
    go(1, 0, 11, 0, 0, 0, 1, 0);
    go(0, 0, 0, 1, 32'h5555, 0, 1, 0);
    go(1, 2'b01, 9, 0, 0, 0, 1, 0);
    go(1, 0, 9, 0, 0, 0, 1, 0);
    go(0, 0, 0, 1, 32'h7777, 0, 1, 0);
    go(1, 2'b11, 11, 0, 0, 0, 1, 0);
    go(1, 0, 11, 0, 0, 0, 1, 0);
    go(0, 0, 0, 1, 32'h8888, 0, 1, 0);
    go(0, 0, 0, 0, 0, 0, 0, 0);
    go(1, 0, 2, 0, 0, 0, 1, 1);
    go(1, 0, 2, 0, 0, 0, 1, 1);
    go(0, 0, 0, 1, 32'h99, 0, 1, 1);
    void'($urandom(32'd2024));
    for (int n = 0; n < 4000; n++) begin
      bit r = ($urandom % 10) < 8;
      int o = (($urandom % 10) < 7) ? 0 : 1 + ($urandom % 3);
      int a = $urandom % 6;
      bit f = ($urandom % 10) < 4;
      bit c = ($urandom % 20) != 0;
      bit idl = !any_wip() && (($urandom % 2) == 1);
      go(r, 2'(o), a, f, DW'($urandom), 1'($urandom), c, idl);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule